// File: doc/BRIEF.md
# Serial Audio Receiver-Pin Sync-Mode Controller

This block is the shared control logic of a serial audio port. It holds one 24-bit control word. That word chooses whether the receive section keeps its own clocking or borrows the clock and frame sync of the transmit side. In the shared-clock (sync) setting, the three receiver-side pins are no longer needed for clocks: the bit-clock pin, the frame-sync pin and the high-frequency-clock pin turn into general flag pins. Each flag pin is an output or an input, as its direction input selects.

Flag outputs do not follow register writes at once. Each register flag bit is copied to its pin only on a boundary event. In normal (single-word-per-frame) operation that event is the frame-start strobe. In multi-slot (network) operation it is the slot-start strobe. Both strobes come from the clock generators outside this block.

With the frame-sync pin set as an output, the frame-sync pin can carry an enable for external transmit buffers instead of flag 1. That enable is high while the transmitter drives a slot. Flag bits of pins set as inputs read back the pin level, resynchronised through two flops. All control and status pins are plain levels with no handshake.

Top module: `srpc_sync_pin_ctrl`

## Requirements
- R1: After reset, rd_data is zero, every pad_oe bit is 0 (all three pins are inputs) and rx_use_tx_clk is 0 (independent clocking).
- R2: The control word has these bits: flag0 at bit 0, flag1 at bit 1, flag2 at bit 2, sync at bit 6, buffer-enable at bit 7 and 16-bit alignment at bit 8. A write stores them on the wr_en clock edge. Bits 5..3 and 23..9 always read as zero.
- R3: With sync=0, rx_use_tx_clk is 0, pad_oe equals pin_dir, and pad_out equals rxgen_out. Pin index 0 is the bit clock, 1 is the frame sync and 2 is the high-frequency clock.
- R4: With sync=1, rx_use_tx_clk is 1, pad_oe equals pin_dir, and each pad_out bit carries its latched flag. The one exception is set by R7.
- R5: With net_mode=0, the latched flags take the register flag bits on a clock edge where frame_start is 1. slot_start has no effect on them.
- R6: With net_mode=1, the latched flags take the register flag bits on a clock edge where slot_start is 1. frame_start has no effect on them.
- R7: With sync=1, pin_dir[1]=1 and buffer-enable=1, pad_out[1] follows tx_slot_active. With buffer-enable=0, pad_out[1] carries flag 1.
- R8: With sync=1 and pin_dir[i]=0, rd_data[i] (i=0..2) returns pad_in[i] through a two-flop synchroniser. A change is seen after the second rising edge. In every other case, rd_data[i] returns the stored flag bit.
- R9: align_16 equals the stored alignment bit (bit 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 24 | Write data |
| rd_data | output | 24 | Read-back of the control word with live flag inputs |
| net_mode | input | 1 | 1 = multi-slot operation (slot-start updates flags) |
| frame_start | input | 1 | Frame boundary strobe |
| slot_start | input | 1 | Slot boundary strobe |
| tx_slot_active | input | 1 | Transmitter is driving the current slot |
| pin_dir | input | 3 | Per-pin direction, 1 = output |
| rxgen_out | input | 3 | Receiver clock generator outputs for the three pins |
| rx_use_tx_clk | output | 1 | Receive section takes clock and frame sync from the transmit generator |
| align_16 | output | 1 | Word alignment to bit 15 selected |
| pad_in | input | 3 | Pin input levels |
| pad_out | output | 3 | Pin output levels |
| pad_oe | output | 3 | Pin output enables |

## Verification
The bench checks that writing a flag bit does not move the pin until the correct boundary strobe arrives. A design that passes writes straight through, or that answers to the wrong strobe for the mode, shows an early pad change. It drives a frame-sync pin set as an input with buffer-enable set. A design that ignores the direction would drive the buffer enable instead of flag 1. It checks the pin read-back one edge after a pin change and again after the second edge. A synchroniser with the wrong depth shows the new level too early or too late. It writes all-ones to the control word to catch reserved bits that do not read as zero.

// File: rtl/srpc_pkg.sv
package srpc_pkg;
  localparam int REG_W   = 24;
  localparam int NPIN    = 3;
  localparam int PIN_SCK = 0;
  localparam int PIN_FS  = 1;
  localparam int PIN_HCK = 2;
  localparam int BIT_SYNC  = 6;
  localparam int BIT_BUFEN = 7;
  localparam int BIT_ALIGN = 8;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic            align;
    logic            bufen;
    logic            sync;
    logic [NPIN-1:0] flag;
  } ctrl_t;
endpackage

// File: rtl/srpc_ctrl_reg.sv
module srpc_ctrl_reg
  import srpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.flag  <= wr_data[NPIN-1:0];
      ctrl.sync  <= wr_data[BIT_SYNC];
      ctrl.bufen <= wr_data[BIT_BUFEN];
      ctrl.align <= wr_data[BIT_ALIGN];
    end
  end
endmodule

// File: rtl/srpc_flag_latch.sv
module srpc_flag_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         net_mode,
  input  logic         frame_start,
  input  logic         slot_start,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic upd;
  assign upd = net_mode ? slot_start : frame_start;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[i] <= 1'b0;
      else if (upd) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/srpc_pin_sync.sv
module srpc_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], din[i]};
    end
    assign dout[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/srpc_pin_mux.sv
module srpc_pin_mux
  import srpc_pkg::*;
(
  input  logic            sync,
  input  logic            bufen,
  input  logic            tx_slot_active,
  input  logic [NPIN-1:0] pin_dir,
  input  logic [NPIN-1:0] flag_q,
  input  logic [NPIN-1:0] rxgen_out,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  for (genvar i = 0; i < NPIN; i++) begin : g_mux
    if (i == PIN_FS) begin : g_fs
      always_comb begin
        if (!sync)                  pad_out[i] = rxgen_out[i];
        else if (bufen && pin_dir[i]) pad_out[i] = tx_slot_active;
        else                        pad_out[i] = flag_q[i];
      end
    end else begin : g_plain
      assign pad_out[i] = sync ? flag_q[i] : rxgen_out[i];
    end
    assign pad_oe[i] = pin_dir[i];
  end
endmodule

// File: rtl/srpc_sync_pin_ctrl.sv
module srpc_sync_pin_ctrl
  import srpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             net_mode,
  input  logic             frame_start,
  input  logic             slot_start,
  input  logic             tx_slot_active,
  input  logic [NPIN-1:0]  pin_dir,
  input  logic [NPIN-1:0]  rxgen_out,
  output logic             rx_use_tx_clk,
  output logic             align_16,
  input  logic [NPIN-1:0]  pad_in,
  output logic [NPIN-1:0]  pad_out,
  output logic [NPIN-1:0]  pad_oe
);
  ctrl_t           ctrl;
  logic [NPIN-1:0] flag_q;
  logic [NPIN-1:0] pin_live;

  srpc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl(ctrl)
  );

  srpc_flag_latch #(.N(NPIN)) u_latch (
    .clk(clk), .rst_n(rst_n), .net_mode(net_mode), .frame_start(frame_start),
    .slot_start(slot_start), .d(ctrl.flag), .q(flag_q)
  );

  srpc_pin_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_live)
  );

  srpc_pin_mux u_mux (
    .sync(ctrl.sync), .bufen(ctrl.bufen), .tx_slot_active(tx_slot_active),
    .pin_dir(pin_dir), .flag_q(flag_q), .rxgen_out(rxgen_out),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[BIT_SYNC]  = ctrl.sync;
    rd_data[BIT_BUFEN] = ctrl.bufen;
    rd_data[BIT_ALIGN] = ctrl.align;
    for (int i = 0; i < NPIN; i++)
      rd_data[i] = (ctrl.sync && !pin_dir[i]) ? pin_live[i] : ctrl.flag[i];
  end

  assign rx_use_tx_clk = ctrl.sync;
  assign align_16      = ctrl.align;
endmodule

// File: rtl/srpc_checker.sv
module srpc_checker
  import srpc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] rd_data,
  input logic             net_mode,
  input logic             frame_start,
  input logic             slot_start,
  input logic             tx_slot_active,
  input logic [NPIN-1:0]  pin_dir,
  input logic [NPIN-1:0]  rxgen_out,
  input logic             rx_use_tx_clk,
  input logic [NPIN-1:0]  pad_out,
  input logic [NPIN-1:0]  pad_oe,
  input logic [NPIN-1:0]  flag_q,
  input logic             sync,
  input logic             bufen
);
  localparam logic [REG_W-1:0] RESV = ~(REG_W'(1 << BIT_SYNC) | REG_W'(1 << BIT_BUFEN) |
                                        REG_W'(1 << BIT_ALIGN) | REG_W'((1 << NPIN) - 1));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == '0 && pad_oe == '0 && !rx_use_tx_clk));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RESV) == '0);

  assert_async_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_use_tx_clk |-> (pad_out == rxgen_out && pad_oe == pin_dir));

  assert_hck_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && pin_dir[PIN_HCK]) |-> (pad_oe[PIN_HCK] && pad_out[PIN_HCK] == flag_q[PIN_HCK]));

  assert_normal_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!net_mode && !frame_start) |=> $stable(flag_q));

  assert_network_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (net_mode && !slot_start) |=> $stable(flag_q));

  assert_buf_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && bufen && pin_dir[PIN_FS]) |-> pad_out[PIN_FS] == tx_slot_active);
endmodule

bind srpc_sync_pin_ctrl srpc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .net_mode(net_mode),
  .frame_start(frame_start), .slot_start(slot_start), .tx_slot_active(tx_slot_active),
  .pin_dir(pin_dir), .rxgen_out(rxgen_out), .rx_use_tx_clk(rx_use_tx_clk),
  .pad_out(pad_out), .pad_oe(pad_oe), .flag_q(flag_q),
  .sync(ctrl.sync), .bufen(ctrl.bufen)
);

// File: tb/tb_srpc_sync_pin_ctrl.sv
`timescale 1ns/1ps
module tb_srpc_sync_pin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [23:0] rd_data;
  logic        net_mode = 1'b0, frame_start = 1'b0, slot_start = 1'b0, tx_slot_active = 1'b0;
  logic [2:0]  pin_dir = '0, rxgen_out = '0, pad_in = '0;
  logic        rx_use_tx_clk, align_16;
  logic [2:0]  pad_out, pad_oe;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  srpc_sync_pin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .net_mode(net_mode), .frame_start(frame_start), .slot_start(slot_start),
    .tx_slot_active(tx_slot_active), .pin_dir(pin_dir), .rxgen_out(rxgen_out),
    .rx_use_tx_clk(rx_use_tx_clk), .align_16(align_16), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct packed {
    logic [8:0] w;
    logic [2:0] dir;
    logic [2:0] gen;
    logic       tx;
    logic [2:0] eout;
    logic [2:0] eoe;
    logic       ertx;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{9'h000, 3'b111, 3'b101, 1'b0, 3'b101, 3'b111, 1'b0},
    '{9'h007, 3'b010, 3'b010, 1'b0, 3'b010, 3'b010, 1'b0},
    '{9'h045, 3'b111, 3'b000, 1'b0, 3'b101, 3'b111, 1'b1},
    '{9'h042, 3'b100, 3'b111, 1'b0, 3'b010, 3'b100, 1'b1},
    '{9'h0C0, 3'b010, 3'b000, 1'b1, 3'b010, 3'b010, 1'b1},
    '{9'h0C4, 3'b111, 3'b000, 1'b0, 3'b100, 3'b111, 1'b1},
    '{9'h0C3, 3'b101, 3'b000, 1'b1, 3'b011, 3'b101, 1'b1}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic pulse_slot();
    @(negedge clk); slot_start = 1'b1;
    @(negedge clk); slot_start = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 24'h0);
    chk("R1 pad_oe", {21'b0, pad_oe}, 24'h0);
    chk("R1 rx_use_tx_clk", {23'b0, rx_use_tx_clk}, 24'h0);

    // table walk: R3 async, R4 sync, R7 buffer enable
    for (int k = 0; k < NV; k++) begin
      wr({15'b0, VEC[k].w});
      pin_dir = VEC[k].dir; rxgen_out = VEC[k].gen; tx_slot_active = VEC[k].tx;
      pulse_frame();
      chk("R3/R4/R7 pad_out", {21'b0, pad_out}, {21'b0, VEC[k].eout});
      chk("R3/R4 pad_oe", {21'b0, pad_oe}, {21'b0, VEC[k].eoe});
      chk("R3/R4 rx_use_tx_clk", {23'b0, rx_use_tx_clk}, {23'b0, VEC[k].ertx});
    end

    // R2 reserved bits, R9 alignment
    pin_dir = 3'b111;
    wr(24'hFFFFFF);
    chk("R2 readback", rd_data, 24'h0001C7);
    chk("R9 align_16", {23'b0, align_16}, 24'h1);
    wr(24'h000040);
    chk("R9 align_16 clear", {23'b0, align_16}, 24'h0);

    // R5 normal mode: slot_start ignored
    net_mode = 1'b0; tx_slot_active = 1'b0;
    wr(24'h000040); pulse_frame();
    chk("R5 baseline", {21'b0, pad_out}, 24'h0);
    wr(24'h000047);
    chk("R5 write alone no change", {21'b0, pad_out}, 24'h0);
    pulse_slot();
    chk("R5 slot ignored", {21'b0, pad_out}, 24'h0);
    pulse_frame();
    chk("R5 frame updates", {21'b0, pad_out}, 24'h7);

    // R6 network mode: frame_start ignored
    net_mode = 1'b1;
    wr(24'h000040);
    pulse_frame();
    chk("R6 frame ignored", {21'b0, pad_out}, 24'h7);
    pulse_slot();
    chk("R6 slot updates", {21'b0, pad_out}, 24'h0);
    net_mode = 1'b0;

    // R7 buffer enable follows tx_slot_active
    wr(24'h0000C2); pin_dir = 3'b010; pulse_frame();
    tx_slot_active = 1'b0; #0.5;
    chk("R7 enable low", {23'b0, pad_out[1]}, 24'h0);
    tx_slot_active = 1'b1; #0.5;
    chk("R7 enable high", {23'b0, pad_out[1]}, 24'h1);
    wr(24'h000040); tx_slot_active = 1'b1; pulse_frame();
    chk("R7 bufen clear gives flag1", {23'b0, pad_out[1]}, 24'h0);

    // R8 input readback through two flops
    pin_dir = 3'b000;
    repeat (3) @(negedge clk);
    pad_in = 3'b101;
    @(negedge clk);
    chk("R8 one edge old value", {21'b0, rd_data[2:0]}, 24'h0);
    @(negedge clk);
    chk("R8 two edges new value", {21'b0, rd_data[2:0]}, 24'h5);
    pin_dir = 3'b111; #0.5;
    chk("R8 output dir reads stored", {21'b0, rd_data[2:0]}, 24'h0);
    wr(24'h000005); pin_dir = 3'b000; pad_in = 3'b010;
    repeat (3) @(negedge clk);
    chk("R8 async reads stored", {21'b0, rd_data[2:0]}, 24'h5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule